// File: doc/BRIEF.md
# DDR SDRAM Command Legality Monitor

This block sits passively on a DDR SDRAM command bus and decodes one command per clock from the clock-enable, chip-select, row/column strobes, write enable, bank address and address lines. It keeps open/closed state and minimum-delay counters for each of four banks. It also keeps a few shared counters: one for the mode-register quiet time, one for the spacing between activates to different banks, and the programmed burst length. Every sampled command is checked against these, and any breach is reported as a single-cycle error pulse with a reason code.

The decoded command, its bank and its auto-precharge bit appear on the monitor outputs one clock after the command edge. The error reason appears on the same clock. Bank and shared state always follow the command as issued, even when the command was illegal, so that later checks stay consistent with what the memory would do. All timing limits are clock-count parameters. The defaults assume a 6 ns clock: activate-to-column 3, precharge period 3, activate-to-activate in different banks 2, minimum row-active 7, maximum row-active 11667, row cycle 10, write recovery 3 and mode-register quiet time 2.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A command is sampled when `cs_n` is low and `cke` was high at the previous clock edge. Otherwise it reads as NOP (0). {ras_n,cas_n,we_n} decodes as follows: 011 is ACT (1), 101 is RD (2), 100 is WR (3), 010 is PRE (4), 110 is BST (5), 001 is REF (6), or SREF (7) when `cke` is low in the same cycle, 000 is MRS (8), and 111 is NOP (0). `mon_op`, `mon_bank` and `mon_ap` show the command one edge after it is sampled. `mon_ap` is `addr[10]` for any command other than NOP.
- R2: `ba` values 0 to 3 address banks 0 to 3. A PRE with `addr[10]` high ignores `ba` and closes every open bank.
- R3: An MRS while any bank is open gives code 2. Any command other than NOP in the clock right after an MRS gives code 1.
- R4: A REF or SREF while any bank is open gives code 3.
- R5: An ACT to an open bank gives code 5. An ACT fewer than 10 clocks after the previous ACT of the same bank gives code 6.
- R6: An ACT fewer than 3 clocks after that bank was closed by PRE gives code 7.
- R7: An ACT fewer than 2 clocks after any other ACT gives code 8.
- R8: A RD or WR to a closed bank gives code 10. A RD or WR fewer than 3 clocks after that bank's ACT gives code 11. Back-to-back column commands one clock apart are legal.
- R9: A PRE that closes a bank fewer than 7 clocks after its ACT gives code 12. A PRE that closes a bank more than 11667 clocks after its ACT gives code 13.
- R10: A PRE that closes a bank fewer than BL/2+3 clocks after a WR to that bank gives code 14.
- R11: A WR with `addr[10]` high closes its bank. A RD or WR to that bank within the next BL/2 clocks gives code 9, and after that gives code 10. The next ACT of the bank needs BL/2+3 clocks after the WR, otherwise code 7. A RD with `addr[10]` high closes its bank with the same ACT spacing.
- R12: An MRS with `ba`=0 sets the burst length from `addr[2:0]`: 1 gives BL2, 2 gives BL4 and 3 gives BL8. Reset gives BL4. Any other value gives code 4 and keeps the old length. An MRS with `ba`≠0 never changes the length or raises code 4.
- R13: Reset clears every output and closes every bank. When several rules are broken, the check order is: code 1, then the command's own codes in ascending order. `err_pulse` is high for exactly the clock in which `err_code` is nonzero.
- R14: BST and NOP raise no error outside the mode-register quiet clock, and a NOP changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable from the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address lines (bit 10 auto/all precharge, bits 2:0 burst code) |
| mon_op | output | 4 | Decoded command code |
| mon_bank | output | 2 | Bank of the decoded command |
| mon_ap | output | 1 | Address bit 10 of the decoded command |
| err_pulse | output | 1 | One-cycle violation flag |
| err_code | output | 4 | Violation reason |

## Verification
The monitor keeps internal bank state, and a wrong value in that state shows up at the ports only when a later command meets it. A bank left open after a precharge-all surfaces as code 3 on the next REF. A counter that was not reloaded shows as a missing or spurious timing code on the first command placed exactly at the limit. Each scenario therefore places commands at the limit and one clock short of it. It then follows an illegal command with a probe command, because the state update applied by the illegal command is visible only through the probe's error code on the next clock.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ACT  = 4'd1,
        OP_RD   = 4'd2,
        OP_WR   = 4'd3,
        OP_PRE  = 4'd4,
        OP_BST  = 4'd5,
        OP_REF  = 4'd6,
        OP_SREF = 4'd7,
        OP_MRS  = 4'd8
    } op_e;

    typedef enum logic [3:0] {
        V_NONE       = 4'd0,
        V_MRS_GAP    = 4'd1,
        V_MODE_OPEN  = 4'd2,
        V_REF_OPEN   = 4'd3,
        V_BL_BAD     = 4'd4,
        V_ACT_OPEN   = 4'd5,
        V_T_RC       = 4'd6,
        V_T_RP       = 4'd7,
        V_T_RRD      = 4'd8,
        V_AP_BUSY    = 4'd9,
        V_COL_CLOSED = 4'd10,
        V_T_RCD      = 4'd11,
        V_T_RAS_MIN  = 4'd12,
        V_T_RAS_MAX  = 4'd13,
        V_T_WR       = 4'd14
    } viol_e;

    typedef struct packed {
        op_e               op;
        logic [BANK_W-1:0] bank;
        logic              a10;
        logic [2:0]        blc;
    } cmd_t;

    typedef struct packed {
        logic open;
        logic ap_busy;
        logic rcd_ok;
        logic ras_ok;
        logic ras_max_ok;
        logic rc_ok;
        logic rp_ok;
        logic wr_ok;
    } bank_stat_t;

    function automatic op_e decode_op(input logic ras_n, input logic cas_n,
                                      input logic we_n, input logic cke_now);
        op_e r;
        case ({ras_n, cas_n, we_n})
            3'b011:  r = OP_ACT;
            3'b101:  r = OP_RD;
            3'b100:  r = OP_WR;
            3'b010:  r = OP_PRE;
            3'b110:  r = OP_BST;
            3'b001:  r = cke_now ? OP_REF : OP_SREF;
            3'b000:  r = OP_MRS;
            default: r = OP_NOP;
        endcase
        return r;
    endfunction

    // Half burst length (clocks of data) for a burst code, 0 when unsupported.
    function automatic logic [2:0] bl_half_of(input logic [2:0] code);
        logic [2:0] r;
        case (code)
            3'd1:    r = 3'd1;
            3'd2:    r = 3'd2;
            3'd3:    r = 3'd4;
            default: r = 3'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chk_cmd_decode.sv
module chk_cmd_decode
    import sdram_chk_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              cmd
);
    logic cke_q;
    logic take;
    logic unused_addr;

    // Clock enable of the previous edge qualifies the present command.
    always_ff @(posedge clk) cke_q <= cke;

    assign take        = cke_q && !cs_n;
    assign unused_addr = ^{addr[ADDR_W-1:11], addr[9:3]};

    always_comb begin
        cmd.op   = take ? decode_op(ras_n, cas_n, we_n, cke) : OP_NOP;
        cmd.bank = ba;
        cmd.a10  = addr[10];
        cmd.blc  = addr[2:0];
    end
endmodule

// File: rtl/chk_bank.sv
module chk_bank
    import sdram_chk_pkg::*;
#(
    parameter int IDX       = 0,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 7,
    parameter int T_RAS_MAX = 11667,
    parameter int T_RC      = 10,
    parameter int T_WR      = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  cmd_t       cmd,
    input  logic [2:0] bl_half,
    output bank_stat_t st
);
    localparam int CNT_W = $clog2(T_RC + T_RP + T_WR + 8);
    localparam int AGE_W = $clog2(T_RAS_MAX + 2);
    localparam int NCNT  = 6;
    localparam int C_RCD = 0;
    localparam int C_RAS = 1;
    localparam int C_RC  = 2;
    localparam int C_RP  = 3;
    localparam int C_WR  = 4;
    localparam int C_AP  = 5;
    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(T_RAS_MAX + 1);

    logic [CNT_W-1:0] cnt [NCNT];
    logic [AGE_W-1:0] age_q;
    logic             open_q;
    logic             is_me, hit_act, hit_col, hit_pre;

    assign is_me   = (cmd.bank == BANK_W'(IDX));
    assign hit_act = (cmd.op == OP_ACT) && is_me;
    assign hit_col = ((cmd.op == OP_RD) || (cmd.op == OP_WR)) && is_me;
    assign hit_pre = (cmd.op == OP_PRE) && (cmd.a10 || is_me);

    // Each counter holds the clocks still missing before its rule is met.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCNT; i++) cnt[i] <= '0;
            age_q  <= '0;
            open_q <= 1'b0;
        end else begin
            for (int i = 0; i < NCNT; i++)
                if (cnt[i] != '0) cnt[i] <= cnt[i] - 1'b1;
            if (open_q && age_q != AGE_SAT) age_q <= age_q + 1'b1;

            if (hit_act) begin
                open_q     <= 1'b1;
                age_q      <= AGE_W'(1);
                cnt[C_RCD] <= CNT_W'(T_RCD - 1);
                cnt[C_RAS] <= CNT_W'(T_RAS - 1);
                cnt[C_RC]  <= CNT_W'(T_RC - 1);
            end
            if (hit_col) begin
                if (cmd.op == OP_WR)
                    cnt[C_WR] <= CNT_W'(int'(bl_half) + T_WR - 1);
                if (cmd.a10) begin
                    open_q    <= 1'b0;
                    cnt[C_RP] <= CNT_W'(int'(bl_half) + T_RP - 1);
                    if (cmd.op == OP_WR)
                        cnt[C_AP] <= CNT_W'(int'(bl_half) - 1);
                end
            end
            if (hit_pre && open_q) begin
                open_q    <= 1'b0;
                cnt[C_RP] <= CNT_W'(T_RP - 1);
            end
        end
    end

    always_comb begin
        st.open       = open_q;
        st.ap_busy    = (cnt[C_AP] != '0);
        st.rcd_ok     = (cnt[C_RCD] == '0);
        st.ras_ok     = (cnt[C_RAS] == '0);
        st.ras_max_ok = (age_q <= AGE_W'(T_RAS_MAX));
        st.rc_ok      = (cnt[C_RC] == '0);
        st.rp_ok      = (cnt[C_RP] == '0);
        st.wr_ok      = (cnt[C_WR] == '0);
    end

    // R5: an activate leaves the bank open on the next clock
    a_r5_act_opens: assert property (@(posedge clk) disable iff (rst)
        hit_act |=> open_q);

    // R11: a bank inside its auto-precharge write burst is never open
    a_r11_ap_bank_closed: assert property (@(posedge clk) disable iff (rst)
        (cnt[C_AP] != '0) |-> !open_q);

    // R6: a precharge of an open bank blocks the next activate timing
    a_r6_pre_blocks_act: assert property (@(posedge clk) disable iff (rst)
        (hit_pre && open_q && !hit_act && T_RP > 1) |=> (cnt[C_RP] != '0));
endmodule

// File: rtl/chk_rule_eval.sv
module chk_rule_eval
    import sdram_chk_pkg::*;
(
    input  cmd_t       cmd,
    input  bank_stat_t st [NBANK],
    input  logic       mrs_busy,
    input  logic       rrd_busy,
    output viol_e      viol
);
    bank_stat_t sel;
    logic any_open, ras_bad, rasmax_bad, wr_bad;

    assign sel = st[cmd.bank];

    always_comb begin
        any_open   = 1'b0;
        ras_bad    = 1'b0;
        rasmax_bad = 1'b0;
        wr_bad     = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            any_open = any_open | st[b].open;
            if ((cmd.a10 || cmd.bank == BANK_W'(b)) && st[b].open) begin
                ras_bad    = ras_bad    | !st[b].ras_ok;
                rasmax_bad = rasmax_bad | !st[b].ras_max_ok;
                wr_bad     = wr_bad     | !st[b].wr_ok;
            end
        end
    end

    // First failing rule in code order wins.
    always_comb begin
        viol = V_NONE;
        if (cmd.op == OP_NOP) begin
            viol = V_NONE;
        end else if (mrs_busy) begin
            viol = V_MRS_GAP;
        end else begin
            unique case (cmd.op)
                OP_MRS: begin
                    if (any_open) viol = V_MODE_OPEN;
                    else if (cmd.bank == '0 && bl_half_of(cmd.blc) == 3'd0)
                        viol = V_BL_BAD;
                end
                OP_REF, OP_SREF: begin
                    if (any_open) viol = V_REF_OPEN;
                end
                OP_ACT: begin
                    if (sel.open)        viol = V_ACT_OPEN;
                    else if (!sel.rc_ok) viol = V_T_RC;
                    else if (!sel.rp_ok) viol = V_T_RP;
                    else if (rrd_busy)   viol = V_T_RRD;
                end
                OP_RD, OP_WR: begin
                    if (sel.ap_busy)      viol = V_AP_BUSY;
                    else if (!sel.open)   viol = V_COL_CLOSED;
                    else if (!sel.rcd_ok) viol = V_T_RCD;
                end
                OP_PRE: begin
                    if (ras_bad)         viol = V_T_RAS_MIN;
                    else if (rasmax_bad) viol = V_T_RAS_MAX;
                    else if (wr_bad)     viol = V_T_WR;
                end
                default: viol = V_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_RAS     = 7,
    parameter int T_RAS_MAX = 11667,
    parameter int T_RC      = 10,
    parameter int T_WR      = 3,
    parameter int T_MRD     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        mon_op,
    output logic [BANK_W-1:0] mon_bank,
    output logic              mon_ap,
    output logic              err_pulse,
    output logic [3:0]        err_code
);
    localparam int GW = $clog2(T_MRD + T_RRD + 2);

    cmd_t       cmd;
    bank_stat_t bst [NBANK];
    viol_e      viol;
    logic [2:0] bl_half_q;
    logic [GW-1:0] mrs_left, rrd_left;
    logic       any_open;

    chk_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .cmd(cmd)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        chk_bank #(
            .IDX(g), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
            .T_RAS_MAX(T_RAS_MAX), .T_RC(T_RC), .T_WR(T_WR)
        ) u_bank (
            .clk(clk), .rst(rst), .cmd(cmd), .bl_half(bl_half_q), .st(bst[g])
        );
    end

    chk_rule_eval u_rules (
        .cmd(cmd), .st(bst), .mrs_busy(mrs_left != '0),
        .rrd_busy(rrd_left != '0), .viol(viol)
    );

    always_comb begin
        any_open = 1'b0;
        for (int b = 0; b < NBANK; b++) any_open = any_open | bst[b].open;
    end

    // Shared state: burst length, mode-register quiet time, activate spacing.
    always_ff @(posedge clk) begin
        if (rst) begin
            bl_half_q <= 3'd2;
            mrs_left  <= '0;
            rrd_left  <= '0;
        end else begin
            if (mrs_left != '0) mrs_left <= mrs_left - 1'b1;
            if (rrd_left != '0) rrd_left <= rrd_left - 1'b1;
            if (cmd.op == OP_MRS) begin
                mrs_left <= GW'(T_MRD - 1);
                if (cmd.bank == '0 && bl_half_of(cmd.blc) != 3'd0)
                    bl_half_q <= bl_half_of(cmd.blc);
            end
            if (cmd.op == OP_ACT) rrd_left <= GW'(T_RRD - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_op    <= '0;
            mon_bank  <= '0;
            mon_ap    <= 1'b0;
            err_pulse <= 1'b0;
            err_code  <= '0;
        end else begin
            mon_op    <= cmd.op;
            mon_bank  <= cmd.bank;
            mon_ap    <= (cmd.op != OP_NOP) && cmd.a10;
            err_pulse <= (viol != V_NONE);
            err_code  <= viol;
        end
    end

    // R1: a deselected bus reads as NOP on the monitor
    a_r1_deselect_nop: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (mon_op == OP_NOP));

    // R13: an error is only ever attached to a real command
    a_r13_err_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (mon_op != OP_NOP));

    // R3: a command right after a mode-register set reports the quiet-time code
    a_r3_mrs_gap: assert property (@(posedge clk) disable iff (rst)
        ((cmd.op == OP_MRS) ##1 (cmd.op != OP_NOP)) |=> (err_code == V_MRS_GAP));

    // R2: precharge-all leaves no bank open
    a_r2_all_closed: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_PRE && cmd.a10 && !$past(cmd.op == OP_MRS)) |=> !any_open);

    // R14: burst stop outside the quiet clock is never flagged
    a_r14_bst_clean: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_BST && mrs_left == '0) |=> !err_pulse);
endmodule

// File: tb/sdram_cmd_checker_test.sv
module sdram_cmd_checker_test;
    localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                           P_PRE = 3'b010, P_BST = 3'b110, P_REF = 3'b001,
                           P_MRS = 3'b000, P_NOP = 3'b111;

    logic clk = 1'b0, rst = 1'b1, cke = 1'b1, cs_n = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [12:0] addr = '0;
    logic [3:0] mon_op, err_code;
    logic [1:0] mon_bank;
    logic mon_ap, err_pulse;

    int n_chk = 0, n_err = 0;
    int got_op, got_err, got_bank, got_ap, got_pulse;

    always #2 clk = ~clk;

    sdram_cmd_checker uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .mon_op(mon_op),
        .mon_bank(mon_bank), .mon_ap(mon_ap), .err_pulse(err_pulse),
        .err_code(err_code)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic sample();
        got_op = mon_op; got_err = err_code; got_bank = mon_bank;
        got_ap = mon_ap; got_pulse = err_pulse;
    endtask

    // Drives one command for one clock; called and returns at a falling edge.
    task automatic drive(input logic [2:0] pat, input int bank, input logic a10,
                         input int lo, input logic sel_n = 1'b0);
        cs_n = sel_n; {ras_n, cas_n, we_n} = pat; ba = 2'(bank);
        addr = '0; addr[10] = a10; addr[2:0] = 3'(lo);
        @(posedge clk); #1; sample();
        @(negedge clk);
        cs_n = 1'b1; {ras_n, cas_n, we_n} = P_NOP;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; cke = 1'b1; cs_n = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_decode();
        do_reset();
        check("R13", "reset op", mon_op, 0);
        check("R13", "reset pulse", err_pulse, 0);
        drive(P_ACT, 2, 1'b0, 0);
        check("R1", "act op", got_op, 1);
        check("R2", "act bank", got_bank, 2);
        check("R13", "legal act pulse", got_pulse, 0);
        drive(P_ACT, 1, 1'b0, 0, 1'b1);
        check("R1", "deselected op", got_op, 0);
        cke = 1'b0; idle(1); cke = 1'b1;
        drive(P_ACT, 1, 1'b0, 0);
        check("R1", "cke low before op", got_op, 0);
        drive(P_BST, 0, 1'b0, 0);
        check("R14", "bst op", got_op, 5);
        check("R14", "bst err", got_err, 0);
        drive(P_NOP, 0, 1'b0, 0);
        check("R14", "nop op", got_op, 0);
    endtask

    task automatic t_mode();
        do_reset();
        drive(P_MRS, 0, 1'b0, 2);
        check("R1", "mrs op", got_op, 8);
        check("R3", "clean mrs", got_err, 0);
        drive(P_ACT, 0, 1'b0, 0);
        check("R3", "cmd after mrs", got_err, 1);
        check("R13", "pulse with code", got_pulse, 1);
        idle(9);
        drive(P_MRS, 0, 1'b0, 2);
        check("R3", "mrs with open bank", got_err, 2);
        do_reset();
        drive(P_MRS, 0, 1'b0, 2); idle(1);
        drive(P_ACT, 0, 1'b0, 0);
        check("R3", "act two clocks after mrs", got_err, 0);
    endtask

    task automatic t_refresh();
        do_reset();
        drive(P_REF, 0, 1'b0, 0);
        check("R1", "ref op", got_op, 6);
        check("R4", "ref idle", got_err, 0);
        drive(P_ACT, 3, 1'b0, 0); idle(1);
        drive(P_REF, 0, 1'b0, 0);
        check("R4", "ref with open bank", got_err, 3);
        cke = 1'b0;
        drive(P_REF, 0, 1'b0, 0);
        check("R1", "sref op", got_op, 7);
        check("R4", "sref with open bank", got_err, 3);
        cke = 1'b1; idle(2);
    endtask

    task automatic t_activate();
        do_reset();
        drive(P_ACT, 0, 1'b0, 0); idle(3);
        drive(P_ACT, 0, 1'b0, 0);
        check("R5", "act open bank", got_err, 5);
        do_reset();
        drive(P_ACT, 0, 1'b0, 0); idle(6);
        drive(P_PRE, 0, 1'b0, 0);
        check("R9", "pre at ras min", got_err, 0);
        drive(P_ACT, 0, 1'b0, 0);
        check("R5", "row cycle short", got_err, 6);
        do_reset();
        drive(P_ACT, 0, 1'b0, 0); idle(8);
        drive(P_PRE, 0, 1'b0, 0); idle(1);
        drive(P_ACT, 0, 1'b0, 0);
        check("R6", "precharge period short", got_err, 7);
        do_reset();
        drive(P_ACT, 0, 1'b0, 0); idle(8);
        drive(P_PRE, 0, 1'b0, 0); idle(2);
        drive(P_ACT, 0, 1'b0, 0);
        check("R6", "precharge period met", got_err, 0);
    endtask

    task automatic t_rrd();
        do_reset();
        drive(P_ACT, 0, 1'b0, 0);
        drive(P_ACT, 1, 1'b0, 0);
        check("R7", "act spacing short", got_err, 8);
        idle(1);
        drive(P_ACT, 2, 1'b0, 0);
        check("R7", "act spacing met", got_err, 0);
    endtask

    task automatic t_column();
        do_reset();
        drive(P_RD, 1, 1'b0, 0);
        check("R1", "rd op", got_op, 2);
        check("R8", "rd closed bank", got_err, 10);
        drive(P_ACT, 1, 1'b0, 0); idle(1);
        drive(P_RD, 1, 1'b0, 0);
        check("R8", "rd too soon", got_err, 11);
        drive(P_RD, 1, 1'b0, 0);
        check("R8", "rd at limit", got_err, 0);
        drive(P_WR, 1, 1'b0, 0);
        check("R8", "wr one clock later", got_err, 0);
    endtask

    task automatic t_ras();
        do_reset();
        drive(P_ACT, 2, 1'b0, 0); idle(4);
        drive(P_PRE, 2, 1'b0, 0);
        check("R9", "pre before ras min", got_err, 12);
        do_reset();
        drive(P_ACT, 0, 1'b0, 0); idle(1);
        drive(P_ACT, 3, 1'b0, 0);
        check("R7", "act at spacing limit", got_err, 0);
        idle(3);
        drive(P_PRE, 0, 1'b1, 0);
        check("R9", "pre-all early", got_err, 12);
        do_reset();
        drive(P_ACT, 0, 1'b0, 0); idle(1);
        drive(P_ACT, 3, 1'b0, 0); idle(9);
        drive(P_PRE, 1, 1'b1, 0);
        check("R2", "pre-all legal", got_err, 0);
        check("R2", "pre-all ap flag", got_ap, 1);
        idle(9);
        drive(P_REF, 0, 1'b0, 0);
        check("R2", "all banks closed", got_err, 0);
        do_reset();
        drive(P_ACT, 1, 1'b0, 0); idle(11667);
        drive(P_PRE, 1, 1'b0, 0);
        check("R9", "pre after ras max", got_err, 13);
    endtask

    task automatic t_burst();
        do_reset();
        drive(P_MRS, 0, 1'b0, 5);
        check("R12", "bad burst code", got_err, 4);
        idle(1);
        drive(P_MRS, 1, 1'b0, 7);
        check("R12", "extended mrs ignores code", got_err, 0);
        idle(1);
        drive(P_MRS, 0, 1'b0, 1); idle(1);
        drive(P_ACT, 0, 1'b0, 0); idle(5);
        drive(P_WR, 0, 1'b0, 0); idle(2);
        drive(P_PRE, 0, 1'b0, 0);
        check("R10", "bl2 write recovery short", got_err, 14);
        do_reset();
        drive(P_MRS, 0, 1'b0, 3); idle(1);
        drive(P_ACT, 1, 1'b0, 0); idle(7);
        drive(P_WR, 1, 1'b0, 0); idle(5);
        drive(P_PRE, 1, 1'b0, 0);
        check("R12", "bl8 write recovery short", got_err, 14);
        do_reset();
        drive(P_MRS, 0, 1'b0, 3); idle(1);
        drive(P_ACT, 1, 1'b0, 0); idle(7);
        drive(P_WR, 1, 1'b0, 0); idle(6);
        drive(P_PRE, 1, 1'b0, 0);
        check("R10", "bl8 write recovery met", got_err, 0);
    endtask

    task automatic t_autopre();
        do_reset();
        drive(P_ACT, 2, 1'b0, 0); idle(6);
        drive(P_WR, 2, 1'b1, 0);
        check("R11", "write ap legal", got_err, 0);
        check("R11", "write ap flag", got_ap, 1);
        drive(P_RD, 2, 1'b0, 0);
        check("R11", "rd during ap burst", got_err, 9);
        drive(P_RD, 2, 1'b0, 0);
        check("R11", "rd after ap burst", got_err, 10);
        drive(P_ACT, 2, 1'b0, 0);
        check("R11", "act too soon after ap", got_err, 7);
        do_reset();
        drive(P_ACT, 2, 1'b0, 0); idle(6);
        drive(P_WR, 2, 1'b1, 0); idle(4);
        drive(P_ACT, 2, 1'b0, 0);
        check("R11", "act after ap window", got_err, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_decode();
        t_mode();
        t_refresh();
        t_activate();
        t_rrd();
        t_column();
        t_burst();
        t_autopre();
        t_ras();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule